// File: doc/BRIEF.md
# Byte-Wide Split Loader for a 12-Bit Converter Code

This block assembles a 12-bit converter code from an 8-bit data bus in two separate write operations. A staging register is split into a low byte and a high nibble. Each part has its own active-low select, and both share one active-low write strobe. Bus data is right-justified, so the high nibble is always taken from the four lowest bus lines. The two parts may be written in either order.

A separate active-low load strobe copies the whole staging register into the output register on its rising edge. Only the output register drives the code seen at the outputs. All control lines are asynchronous to the block clock and pass through two flip-flop stages before edge detection. The bus is sampled in the clock cycle in which a capture edge is detected, so the bus must be held stable for a few clock cycles after the strobe is released.

Top module: `split_code_loader`

## Requirements
- R1: While reset is asserted, and after it is released, both the staging register and `dacCode` are zero.
- R2: A write with `selLoN` low loads bus bits 7..0 into staging bits 7..0. Staging bits 11..8 are left unchanged.
- R3: A write with `selHiN` low loads bus bits 3..0 into staging bits 11..8. Bus bits 7..4 are ignored, and staging bits 7..0 are left unchanged.
- R4: Capture takes place when the overlap of write low and select low ends, whether `wrN` or the select rises first. A write strobe with both selects high has no effect, and neither does a select pulse with `wrN` high.
- R5: Writing the low byte and the high nibble in either order gives the same final code.
- R6: `dacCode` changes only after a rising edge of `loadN`. Writes alone, and `loadN` held low, leave it unchanged.
- R7: A load transfers all 12 staging bits to `dacCode`, including parts written before earlier loads.
- R8: If both selects are low during one write, both parts load from the same bus byte: the code becomes {bus[3:0], bus[7:0]}.
- R9: After `loadN` rises between clock edges, `dacCode` still holds the old value after two rising clock edges and shows the new value after the third.
- R10: If a capture and a load are detected in the same cycle, `dacCode` takes the newly captured data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busData | input | 8 | Right-justified data bus |
| selLoN | input | 1 | Active-low select for the low byte |
| selHiN | input | 1 | Active-low select for the high nibble |
| wrN | input | 1 | Active-low shared write strobe |
| loadN | input | 1 | Active-low load strobe; transfers on its rising edge |
| dacCode | output | 12 | Registered converter code |

## Verification
The staging register is not visible at the ports, so a wrong staging value shows up only after the next load. It appears on `dacCode` three clock edges after `loadN` rises, which is why every write scenario ends with a load. A misrouted nibble, a missed capture or a capture from the wrong select gives a wrong code at that point. A stray update of the output register shows up immediately as a changed `dacCode` while no load has been issued.

// File: rtl/split_code_loader_pkg.sv
package split_code_loader_pkg;

  typedef struct packed {
    logic capLo;
    logic capHi;
    logic loadDac;
  } strobeT;

endpackage

// File: rtl/split_code_loader_ctrl.sv
module split_code_loader_ctrl
  import split_code_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrN,
  input  logic   selLoN,
  input  logic   selHiN,
  input  logic   loadN,
  output strobeT strb
);

  localparam int N_CTRL = 4;
  localparam int IDX_WR = 0;
  localparam int IDX_LO = 1;
  localparam int IDX_HI = 2;
  localparam int IDX_LD = 3;

  logic [N_CTRL-1:0] rawIn;
  logic [N_CTRL-1:0] syncStage [SYNC_STAGES];
  logic [N_CTRL-1:0] syncNow;
  logic [N_CTRL-1:0] syncPrev;

  assign rawIn = {loadN, selHiN, selLoN, wrN};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncStage[g] <= '1;
        end else if (g == 0) begin
          syncStage[g] <= rawIn;
        end else begin
          syncStage[g] <= syncStage[(g > 0) ? g-1 : 0];
        end
      end
    end
  endgenerate

  assign syncNow = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= '1;
    end else begin
      syncPrev <= syncNow;
    end
  end

  logic loActNow, loActPrev, hiActNow, hiActPrev;

  always_comb begin
    loActNow  = !syncNow[IDX_WR]  && !syncNow[IDX_LO];
    loActPrev = !syncPrev[IDX_WR] && !syncPrev[IDX_LO];
    hiActNow  = !syncNow[IDX_WR]  && !syncNow[IDX_HI];
    hiActPrev = !syncPrev[IDX_WR] && !syncPrev[IDX_HI];
    strb.capLo   = loActPrev && !loActNow;
    strb.capHi   = hiActPrev && !hiActNow;
    strb.loadDac = !syncPrev[IDX_LD] && syncNow[IDX_LD];
  end

  // R4: a capture is a single-cycle event per ended overlap
  a_r4_caplo_single: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLo |=> !strb.capLo);
  a_r4_caphi_single: assert property (@(posedge clk) disable iff (!rstN)
    strb.capHi |=> !strb.capHi);
  // R6: one load event per rising edge of the load strobe
  a_r6_load_single: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDac |=> !strb.loadDac);

endmodule

// File: rtl/split_code_loader_dp.sv
module split_code_loader_dp
  import split_code_loader_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busData,
  input  strobeT            strb,
  output logic [CODE_W-1:0] dacCode
);

  localparam int HI_W = CODE_W - DATA_W;

  logic [CODE_W-1:0] inReg;
  logic [CODE_W-1:0] inNext;

  always_comb begin
    inNext = inReg;
    if (strb.capLo) begin
      inNext[DATA_W-1:0] = busData;
    end
    if (strb.capHi) begin
      inNext[CODE_W-1:DATA_W] = busData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg <= '0;
    end else begin
      inReg <= inNext;
    end
  end

  // forwarding: a load in the capture cycle takes the fresh word (R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode <= '0;
    end else if (strb.loadDac) begin
      dacCode <= inNext;
    end
  end

  // R6: output register holds without a load event
  a_r6_dac_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadDac |=> $stable(dacCode));
  // R2: low byte holds without a low capture
  a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capLo |=> $stable(inReg[DATA_W-1:0]));
  // R3: high nibble holds without a high capture
  a_r3_hi_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capHi |=> $stable(inReg[CODE_W-1:DATA_W]));
  // R7: a plain load copies the full staging word
  a_r7_full_load: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadDac && !strb.capLo && !strb.capHi) |=> (dacCode == $past(inReg)));

endmodule

// File: rtl/split_code_loader.sv
module split_code_loader
  import split_code_loader_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busData,
  input  logic              selLoN,
  input  logic              selHiN,
  input  logic              wrN,
  input  logic              loadN,
  output logic [CODE_W-1:0] dacCode
);

  strobeT strb;

  split_code_loader_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrN    (wrN),
    .selLoN (selLoN),
    .selHiN (selHiN),
    .loadN  (loadN),
    .strb   (strb)
  );

  split_code_loader_dp #(
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .busData (busData),
    .strb    (strb),
    .dacCode (dacCode)
  );

  // R1: code is zero while in reset
  a_r1_reset_zero: assert property (@(posedge clk) !rstN |-> (dacCode == '0));

endmodule

// File: tb/split_code_loader_tb.sv
module split_code_loader_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busData = 8'h00;
  logic        selLoN = 1'b1;
  logic        selHiN = 1'b1;
  logic        wrN = 1'b1;
  logic        loadN = 1'b1;
  logic [11:0] dacCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_code_loader dut_i (
    .clk(clk), .rstN(rstN), .busData(busData), .selLoN(selLoN),
    .selHiN(selHiN), .wrN(wrN), .loadN(loadN), .dacCode(dacCode)
  );

  task automatic check(input string req, input logic [11:0] exp);
    checks++;
    if (dacCode !== exp) begin
      errors++;
      $display("FAIL %s: dacCode=%h expected=%h", req, dacCode, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // lo/hi pick selects; selFirst releases the select before the write strobe
  task automatic doWrite(input logic lo, input logic hi, input logic [7:0] d,
                         input logic selFirst);
    @(negedge clk);
    busData = d; selLoN = !lo; selHiN = !hi; wrN = 1'b0;
    waitN(3);
    if (selFirst) begin
      selLoN = 1'b1; selHiN = 1'b1;
      waitN(2);
      wrN = 1'b1;
    end else begin
      wrN = 1'b1;
      waitN(2);
      selLoN = 1'b1; selHiN = 1'b1;
    end
    waitN(4);
    busData = 8'h5A;
  endtask

  task automatic doLoad();
    @(negedge clk);
    loadN = 1'b0;
    waitN(3);
    loadN = 1'b1;
    waitN(4);
  endtask

  task automatic tReset();
    check("R1", 12'h000);
    doLoad();
    check("R1", 12'h000);
  endtask

  task automatic tLoThenHi();
    doWrite(1, 0, 8'h3C, 0);
    check("R6", 12'h000);
    doWrite(0, 1, 8'hA7, 0);
    check("R6", 12'h000);
    doLoad();
    check("R3", 12'h73C);
  endtask

  task automatic tOrder();
    doWrite(1, 0, 8'hB4, 0);
    doWrite(0, 1, 8'h06, 0);
    doLoad();
    check("R5", 12'h6B4);
    doWrite(1, 1, 8'h00, 0);
    doLoad();
    check("R5", 12'h000);
    doWrite(0, 1, 8'h06, 0);
    doWrite(1, 0, 8'hB4, 0);
    doLoad();
    check("R5", 12'h6B4);
  endtask

  task automatic tSelFirst();
    doWrite(1, 0, 8'hE1, 1);
    doWrite(0, 1, 8'hF9, 1);
    doLoad();
    check("R4", 12'h9E1);
  endtask

  task automatic tNoEffect();
    @(negedge clk);
    busData = 8'hFF; wrN = 1'b0;
    waitN(3); wrN = 1'b1; waitN(4);
    selLoN = 1'b0; selHiN = 1'b0;
    waitN(3); selLoN = 1'b1; selHiN = 1'b1; waitN(4);
    doLoad();
    check("R4", 12'h9E1);
  endtask

  task automatic tPartial();
    doWrite(1, 0, 8'h42, 0);
    doLoad();
    check("R2", 12'h942);
    doWrite(0, 1, 8'hF3, 0);
    doLoad();
    check("R7", 12'h342);
  endtask

  task automatic tBoth();
    doWrite(1, 1, 8'hC5, 0);
    doLoad();
    check("R8", 12'h5C5);
  endtask

  task automatic tLoadLevel();
    doWrite(1, 0, 8'h18, 0);
    @(negedge clk);
    loadN = 1'b0;
    waitN(8);
    check("R6", 12'h5C5);
    loadN = 1'b1;
    waitN(2);
    check("R9", 12'h5C5);
    waitN(1);
    check("R9", 12'h518);
    waitN(3);
  endtask

  task automatic tSameCycle();
    @(negedge clk);
    busData = 8'h77; selLoN = 1'b0; wrN = 1'b0; loadN = 1'b0;
    waitN(3);
    wrN = 1'b1; loadN = 1'b1;
    waitN(4);
    selLoN = 1'b1;
    check("R10", 12'h577);
    waitN(2);
  endtask

  initial begin
    waitN(3);
    check("R1", 12'h000);
    rstN = 1'b1;
    waitN(2);
    tReset();
    tLoThenHi();
    tOrder();
    tSelFirst();
    tNoEffect();
    tPartial();
    tBoth();
    tLoadLevel();
    tSameCycle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule